// File: doc/BRIEF.md
# Host Word Read Port for a Disc Sector Buffer

This block is the CPU-facing side of a disc decoder's sector buffer. Software first loads a byte count and a start address. It sets the transfer-enable bit in the interface control register and then strobes the trigger. From that point either the main CPU or the sub CPU pulls 16-bit words out of the buffer, one read strobe per word. The destination select code decides which of the two readers may take data.

Each accepted read returns two consecutive buffer bytes, with the lower address in the high half of the word. It lowers the byte count by two and moves the address on by two. When the count runs out, the block ends the transfer. It raises the end flag, drops data-ready and releases the active-low busy status. If enabled, it also lowers the active-low end-interrupt status and sends a one-cycle interrupt request. A later acknowledge strobe restores the interrupt status. Clearing the enable bit stops a transfer at once.

Top module: `hostxfer_port`

## Requirements
- R1: A trigger strobe starts a transfer only while bit 1 of the stored interface control byte is 1. A start drives `statInProgN` to 0 and `xferEnd` to 0. It sets `dataReady` to 1 when `destSel` is 2 or 3. With bit 1 at 0, a trigger leaves every output unchanged.
- R2: A control write with data bit 1 at 0 aborts the transfer. On the next cycle `byteCount` is 0 and `statInProgN` is 1, and `xferEnd` is left as it was.
- R3: A read strobe is refused when no transfer is active. It is also refused when the reader does not match the select code: the main CPU (`readerIsSub`=0) needs `destSel`=2 and the sub CPU needs `destSel`=3. A refused read gives `rdData`=0 and leaves `byteCount` and `addrCount` unchanged.
- R4: An accepted read makes `rdValid` high one cycle after the strobe, with `rdData` = {buf[addrCount], buf[addrCount+1]}. On the same edge `byteCount` falls by 2 and `addrCount` rises by 2, both wrapping at their width.
- R5: An accepted read with `byteCount` at 2 or below still delivers its word. It sets `byteCount` to 0, `xferEnd` to 1, `dataReady` to 0 and `statInProgN` to 1, and later reads are refused.
- R6: A transfer end with control bit 6 at 1 drives `statEndIrqN` to 0. `irqReq` pulses high for exactly one cycle only when `irqMask` is also 1. With control bit 6 at 0, `statEndIrqN` stays 1.
- R7: An acknowledge strobe sets `statEndIrqN` back to 1.
- R8: After reset: `byteCount`=0, `addrCount`=0, `statInProgN`=1, `statEndIrqN`=1, `xferEnd`=0, `dataReady`=0, `irqReq`=0, `rdValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWr | input | 1 | Write strobe for the interface control byte |
| ctrlData | input | 8 | Control byte: bit 1 transfer enable, bit 6 end-interrupt enable |
| trigWr | input | 1 | Transfer trigger strobe |
| ackWr | input | 1 | End-interrupt acknowledge strobe |
| cntWr | input | 1 | Load strobe for the byte count |
| cntData | input | CNT_W | Byte count value to load |
| addrWr | input | 1 | Load strobe for the buffer address |
| addrData | input | ADDR_W | Buffer address value to load |
| bufWr | input | 1 | Buffer fill write strobe |
| bufWrAddr | input | ADDR_W | Buffer fill address |
| bufWrData | input | 8 | Buffer fill byte |
| destSel | input | 3 | Destination select code |
| readerIsSub | input | 1 | 1 when the sub CPU issues the read, 0 for the main CPU |
| irqMask | input | 1 | Interrupt mask bit for the end request |
| rdStrobe | input | 1 | Host word read strobe |
| rdData | output | 16 | Word returned for the previous read strobe |
| rdValid | output | 1 | rdData holds the result of a read |
| dataReady | output | 1 | Words are waiting for a host reader |
| xferEnd | output | 1 | Transfer has ended |
| statInProgN | output | 1 | Active-low transfer-in-progress status |
| statEndIrqN | output | 1 | Active-low end-interrupt status |
| irqReq | output | 1 | One-cycle end interrupt request |
| byteCount | output | CNT_W | Remaining byte count |
| addrCount | output | ADDR_W | Current buffer read address |

## Verification
The hardest case to reach is the final read of a transfer that was loaded with an odd count. The count there drops below zero rather than to exactly zero. That same read must still deliver its word and raise the end flag and interrupt. The stimulus table loads a count of 9 and mixes refused reads into the accepted ones, so the count passes through 1 before that last read. A second directed transfer starts from a count of 0 with the interrupt enabled and unmasked, so its very first read ends it. A third transfer ends with the interrupt enabled but masked, so the status drops while no request pulse goes out.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam logic [2:0] SEL_MAIN = 3'd2;
  localparam logic [2:0] SEL_SUB  = 3'd3;
  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_IRQ_BIT = 6;

  typedef struct packed {
    logic start;
    logic abort;
    logic step;
    logic finish;
  } hxStrobe_t;
endpackage

// File: rtl/hx_ctrl.sv
module hx_ctrl
  import hx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlData,
  input  logic       trigWr,
  input  logic       ackWr,
  input  logic [2:0] destSel,
  input  logic       readerIsSub,
  input  logic       irqMask,
  input  logic       rdStrobe,
  input  logic       cntLow,
  output hxStrobe_t  strb,
  output logic       dataReady,
  output logic       xferEnd,
  output logic       statInProgN,
  output logic       statEndIrqN,
  output logic       irqReq
);
  logic [7:0] ctrlReg;
  logic       busy;
  logic       selMatch;

  assign selMatch = readerIsSub ? (destSel == SEL_SUB) : (destSel == SEL_MAIN);

  always_comb begin
    strb.abort  = ctrlWr & ~ctrlData[CTRL_EN_BIT];
    strb.start  = trigWr & ~ctrlWr & ctrlReg[CTRL_EN_BIT];
    strb.step   = rdStrobe & ~ctrlWr & ~trigWr & busy & selMatch;
    strb.finish = strb.step & cntLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      busy        <= 1'b0;
      dataReady   <= 1'b0;
      xferEnd     <= 1'b0;
      statInProgN <= 1'b1;
      statEndIrqN <= 1'b1;
      irqReq      <= 1'b0;
    end else begin
      irqReq <= strb.finish & ctrlReg[CTRL_IRQ_BIT] & irqMask;
      if (ctrlWr) ctrlReg <= ctrlData;
      if (ackWr) statEndIrqN <= 1'b1;
      if (strb.abort) begin
        busy        <= 1'b0;
        statInProgN <= 1'b1;
      end else if (strb.start) begin
        busy        <= 1'b1;
        statInProgN <= 1'b0;
        xferEnd     <= 1'b0;
        dataReady   <= (destSel == SEL_MAIN) || (destSel == SEL_SUB);
      end else if (strb.finish) begin
        busy        <= 1'b0;
        statInProgN <= 1'b1;
        xferEnd     <= 1'b1;
        dataReady   <= 1'b0;
        if (ctrlReg[CTRL_IRQ_BIT]) statEndIrqN <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hx_datapath.sv
module hx_datapath
  import hx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hxStrobe_t         strb,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntData,
  input  logic              addrWr,
  input  logic [ADDR_W-1:0] addrData,
  input  logic              bufWr,
  input  logic [ADDR_W-1:0] bufWrAddr,
  input  logic [7:0]        bufWrData,
  input  logic              rdStrobe,
  output logic              cntLow,
  output logic [CNT_W-1:0]  byteCount,
  output logic [ADDR_W-1:0] addrCount,
  output logic [15:0]       rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(2);

  logic [7:0]        mem [DEPTH];
  logic [7:0]        hiByte, loByte;
  logic              stepD;
  logic [ADDR_W-1:0] addrNext;

  assign addrNext = addrCount + ADDR_W'(1);
  assign cntLow   = byteCount <= CNT_STEP;
  assign rdData   = stepD ? {hiByte, loByte} : 16'h0000;

  always_ff @(posedge clk) begin
    if (bufWr) mem[bufWrAddr] <= bufWrData;
    if (strb.step) begin
      hiByte <= mem[addrCount];
      loByte <= mem[addrNext];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount <= '0;
      addrCount <= '0;
      stepD     <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      stepD   <= strb.step;
      rdValid <= rdStrobe;
      if (strb.abort) byteCount <= '0;
      else if (strb.finish) byteCount <= '0;
      else if (strb.step) byteCount <= byteCount - CNT_STEP;
      else if (cntWr) byteCount <= cntData;
      if (strb.step) addrCount <= addrCount + ADDR_STEP;
      else if (addrWr) addrCount <= addrData;
    end
  end
endmodule

// File: rtl/hostxfer_port.sv
module hostxfer_port
  import hx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [7:0]        ctrlData,
  input  logic              trigWr,
  input  logic              ackWr,
  input  logic              cntWr,
  input  logic [CNT_W-1:0]  cntData,
  input  logic              addrWr,
  input  logic [ADDR_W-1:0] addrData,
  input  logic              bufWr,
  input  logic [ADDR_W-1:0] bufWrAddr,
  input  logic [7:0]        bufWrData,
  input  logic [2:0]        destSel,
  input  logic              readerIsSub,
  input  logic              irqMask,
  input  logic              rdStrobe,
  output logic [15:0]       rdData,
  output logic              rdValid,
  output logic              dataReady,
  output logic              xferEnd,
  output logic              statInProgN,
  output logic              statEndIrqN,
  output logic              irqReq,
  output logic [CNT_W-1:0]  byteCount,
  output logic [ADDR_W-1:0] addrCount
);
  hxStrobe_t strb;
  logic      cntLow;

  hx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .trigWr(trigWr), .ackWr(ackWr), .destSel(destSel),
    .readerIsSub(readerIsSub), .irqMask(irqMask), .rdStrobe(rdStrobe),
    .cntLow(cntLow), .strb(strb), .dataReady(dataReady), .xferEnd(xferEnd),
    .statInProgN(statInProgN), .statEndIrqN(statEndIrqN), .irqReq(irqReq)
  );

  hx_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cntWr(cntWr), .cntData(cntData),
    .addrWr(addrWr), .addrData(addrData), .bufWr(bufWr),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .rdStrobe(rdStrobe),
    .cntLow(cntLow), .byteCount(byteCount), .addrCount(addrCount),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/hostxfer_port_chk.sv
module hostxfer_port_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWr,
  input logic [7:0]        ctrlData,
  input logic              trigWr,
  input logic              ackWr,
  input logic              cntWr,
  input logic              addrWr,
  input logic [2:0]        destSel,
  input logic              readerIsSub,
  input logic              rdStrobe,
  input logic [15:0]       rdData,
  input logic              rdValid,
  input logic              dataReady,
  input logic              xferEnd,
  input logic              statInProgN,
  input logic              statEndIrqN,
  input logic              irqReq,
  input logic [CNT_W-1:0]  byteCount,
  input logic [ADDR_W-1:0] addrCount
);
  logic quiet, readerOk;
  assign quiet    = !ctrlWr && !trigWr && !cntWr && !addrWr;
  assign readerOk = readerIsSub ? (destSel == 3'd3) : (destSel == 3'd2);

  p_abort_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !ctrlData[1] |=> byteCount == '0 && statInProgN);

  p_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && quiet && (statInProgN || !readerOk)
    |=> rdValid && rdData == 16'h0 && byteCount == $past(byteCount)
        && addrCount == $past(addrCount));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && quiet && !statInProgN && readerOk && byteCount > CNT_W'(2)
    |=> rdValid && byteCount == $past(byteCount) - CNT_W'(2)
        && addrCount == $past(addrCount) + ADDR_W'(2));

  p_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && quiet && !statInProgN && readerOk && byteCount <= CNT_W'(2)
    |=> byteCount == '0 && xferEnd && !dataReady && statInProgN);

  p_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    ackWr |=> statEndIrqN);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

  p_irq_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !statEndIrqN && xferEnd);
endmodule

bind hostxfer_port hostxfer_port_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
  .trigWr(trigWr), .ackWr(ackWr), .cntWr(cntWr), .addrWr(addrWr),
  .destSel(destSel), .readerIsSub(readerIsSub), .rdStrobe(rdStrobe),
  .rdData(rdData), .rdValid(rdValid), .dataReady(dataReady),
  .xferEnd(xferEnd), .statInProgN(statInProgN), .statEndIrqN(statEndIrqN),
  .irqReq(irqReq), .byteCount(byteCount), .addrCount(addrCount)
);

// File: tb/hostxfer_port_tb_top.sv
`timescale 1ns/100ps
module hostxfer_port_tb_top;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 0, trigWr = 0, ackWr = 0, cntWr = 0, addrWr = 0, bufWr = 0;
  logic [7:0] ctrlData = 0, bufWrData = 0;
  logic [CNT_W-1:0] cntData = 0;
  logic [ADDR_W-1:0] addrData = 0, bufWrAddr = 0;
  logic [2:0] destSel = 0;
  logic readerIsSub = 0, irqMask = 0, rdStrobe = 0;
  logic [15:0] rdData;
  logic rdValid, dataReady, xferEnd, statInProgN, statEndIrqN, irqReq;
  logic [CNT_W-1:0] byteCount;
  logic [ADDR_W-1:0] addrCount;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostxfer_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (.*);

  // {destSel, readerIsSub, expData, expCount, expAddr}; buffer byte at a is (3a+1) mod 256
  localparam logic [43:0] VEC [8] = '{
    {3'd2, 1'b0, 16'h0D10, 16'd7, 8'd6},
    {3'd2, 1'b1, 16'h0000, 16'd7, 8'd6},
    {3'd3, 1'b0, 16'h0000, 16'd7, 8'd6},
    {3'd3, 1'b1, 16'h1316, 16'd5, 8'd8},
    {3'd2, 1'b0, 16'h191C, 16'd3, 8'd10},
    {3'd2, 1'b0, 16'h1F22, 16'd1, 8'd12},
    {3'd2, 1'b0, 16'h2528, 16'd0, 8'd14},
    {3'd2, 1'b0, 16'h0000, 16'd0, 8'd14}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    ctrlWr = 0; trigWr = 0; ackWr = 0; cntWr = 0; addrWr = 0; bufWr = 0; rdStrobe = 0;
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    @(negedge clk); ctrlWr = 1; ctrlData = d; cycle();
  endtask

  task automatic setup(input logic [15:0] cnt, input logic [7:0] adr);
    @(negedge clk); cntWr = 1; cntData = cnt; addrWr = 1; addrData = adr; cycle();
  endtask

  task automatic trigger();
    @(negedge clk); trigWr = 1; cycle();
  endtask

  task automatic hostRead(input logic [2:0] sel, input logic sub);
    @(negedge clk); destSel = sel; readerIsSub = sub; rdStrobe = 1; cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R8 reset state
    check("R8 byteCount", byteCount, 0);
    check("R8 addrCount", addrCount, 0);
    check("R8 statInProgN", statInProgN, 1);
    check("R8 statEndIrqN", statEndIrqN, 1);
    check("R8 xferEnd", xferEnd, 0);
    check("R8 dataReady", dataReady, 0);
    check("R8 irqReq", irqReq, 0);
    check("R8 rdValid", rdValid, 0);

    for (int i = 0; i < 64; i++) begin
      @(negedge clk); bufWr = 1; bufWrAddr = 8'(i); bufWrData = 8'(3 * i + 1); cycle();
    end

    // R1 trigger without enable is ignored
    setup(16'd9, 8'd4);
    destSel = 3'd2;
    trigger();
    check("R1 no-enable statInProgN", statInProgN, 1);
    check("R1 no-enable dataReady", dataReady, 0);
    hostRead(3'd2, 1'b0);
    check("R1/R3 no-enable read data", rdData, 0);
    check("R1/R3 no-enable count", byteCount, 9);

    // R1 start, then table walk for R3 R4 R5
    wrCtrl(8'h02);
    trigger();
    check("R1 start statInProgN", statInProgN, 0);
    check("R1 start dataReady", dataReady, 1);
    check("R1 start xferEnd", xferEnd, 0);
    for (int i = 0; i < 8; i++) begin
      hostRead(VEC[i][43:41], VEC[i][40]);
      check("R3/R4 rdValid", rdValid, 1);
      check("R3/R4 rdData", rdData, VEC[i][39:24]);
      check("R3/R4 byteCount", byteCount, VEC[i][23:8]);
      check("R3/R4 addrCount", addrCount, VEC[i][7:0]);
    end
    check("R5 xferEnd", xferEnd, 1);
    check("R5 dataReady", dataReady, 0);
    check("R5 statInProgN", statInProgN, 1);
    check("R6 no irq enable keeps status", statEndIrqN, 1);

    // R6 count 0 start: first read ends with irq enabled and unmasked
    wrCtrl(8'h42);
    irqMask = 1;
    setup(16'd0, 8'd32);
    destSel = 3'd3;
    trigger();
    hostRead(3'd3, 1'b1);
    check("R5 last word from count 0", rdData, 16'h6164);
    check("R5 count clamps", byteCount, 0);
    check("R6 irqReq pulse", irqReq, 1);
    check("R6 statEndIrqN low", statEndIrqN, 0);
    cycle();
    check("R6 irqReq one cycle", irqReq, 0);
    check("R6 status held", statEndIrqN, 0);
    @(negedge clk); ackWr = 1; cycle();
    check("R7 ack restores", statEndIrqN, 1);

    // R6 masked: status drops, no request
    irqMask = 0;
    setup(16'd2, 8'd0);
    trigger();
    hostRead(3'd3, 1'b1);
    check("R6 masked word", rdData, 16'h0104);
    check("R6 masked irqReq", irqReq, 0);
    check("R6 masked status", statEndIrqN, 0);
    @(negedge clk); ackWr = 1; cycle();

    // R2 abort mid transfer
    setup(16'd100, 8'd0);
    trigger();
    hostRead(3'd3, 1'b1);
    check("R2 pre-abort count", byteCount, 98);
    wrCtrl(8'h00);
    check("R2 abort count", byteCount, 0);
    check("R2 abort statInProgN", statInProgN, 1);
    check("R2 abort xferEnd kept", xferEnd, 0);
    hostRead(3'd3, 1'b1);
    check("R2/R3 read after abort", rdData, 0);
    check("R2/R3 addr after abort", addrCount, 2);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule